// File: doc/BRIEF.md
# Clock Output Test and High-Impedance Selector

This block sits between a clock generator's internal clock sources and its output pads. For every output pin it chooses one of three things: the pin's normal clock, a clock derived from an external test clock, or no drive at all. A 2-bit mode field makes the choice for the whole block. In normal operation, a per-pin enable vector can hold any single pin low while the others keep running.

In test mode the block ignores the normal sources. Each output group then carries its own fixed ratio of the test clock. Processor, memory and USB pins run at half rate. PCI pins, the free-running PCI pin and the IO pin run at quarter rate. Reference and interrupt-controller pins pass the test clock through unchanged. The two dividers are clocked by the test clock. They are held cleared whenever test mode is not selected, so each entry into test mode starts with both divided clocks rising on the same test-clock edge.

Top module: `clk_test_mux`

## Requirements
- R1: Pin order in `pin_out`, `pin_oe` and `out_en` (default sizes) is: processor 0-3, PCI 4-9, free-running PCI 10, memory 11-18, reference 19-20, interrupt controller 21, USB 22, IO 23. In normal mode (`mode` 2'b00, and the reserved code 2'b10 treated the same way), each pin drives its group's source clock ANDed with its enable bit, and every `pin_oe` bit is 1.
- R2: In normal mode, a pin whose `out_en` bit is 0 drives 0 whatever its source does.
- R3: In high-impedance mode (`mode` 2'b11), every `pin_oe` bit is 0 and every `pin_out` bit is 0, whatever the enables, sources or test clock do.
- R4: In test mode (`mode` 2'b01), the processor, memory and USB pins carry the test clock divided by 2.
- R5: In test mode, the PCI pins, the free-running PCI pin and the IO pin carry the test clock divided by 4.
- R6: In test mode, the reference and interrupt-controller pins follow `tclk` directly: high while it is high, low while it is low.
- R7: Both dividers are held at 0 while `mode` is not 2'b01. On the k-th rising `tclk` edge after test mode is selected, the half-rate output is 1 for odd k. The quarter-rate output is 1 for k mod 4 equal to 1 or 2. Both therefore rise together on the first edge, including on every re-entry.
- R8: In test mode, `out_en` and the normal source clocks have no effect, and every `pin_oe` bit is 1.
- R9: While `rst_n` is low, both dividers are cleared at once, without waiting for a `tclk` edge, so every divided pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the dividers |
| tclk | input | 1 | External test clock |
| mode | input | 2 | 00 normal, 01 test, 10 reserved (normal), 11 high impedance |
| out_en | input | 24 | Per-pin enable for normal mode |
| cpu_clk | input | 1 | Normal processor clock source |
| pci_clk | input | 1 | Normal PCI clock source, also feeds the free-running pin |
| mem_clk | input | 1 | Normal memory clock source |
| ref_clk | input | 1 | Normal reference clock source |
| apic_clk | input | 1 | Normal interrupt-controller clock source |
| usb_clk | input | 1 | Normal USB clock source |
| io_clk | input | 1 | Normal IO clock source |
| pin_out | output | 24 | Per-pin output data |
| pin_oe | output | 24 | Per-pin output enable, 1 drives the pad |

## Verification
The properties assume that `mode` changes only while `tclk` is low and stays put across each rising edge. They also assume that the inputs hold known values from time zero, so the divider-phase checks that compare against the previous edge see a settled mode. The stimulus changes `mode`, `out_en` and the source levels only just after a falling `tclk` edge. It holds static levels on the normal sources, so every output can be predicted from the requirements alone. Test-mode runs of different lengths, and re-entries at different divider phases, exercise the alignment rule. An asynchronous reset during a high divider phase checks that the clear does not wait for a clock edge.

// File: rtl/clk_test_mux.sv
module clk_test_mux #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 6,
  parameter int N_MEM = 8,
  parameter int N_REF = 2,
  localparam int O_CPU  = 0,
  localparam int O_PCI  = O_CPU + N_CPU,
  localparam int O_PCIF = O_PCI + N_PCI,
  localparam int O_MEM  = O_PCIF + 1,
  localparam int O_REF  = O_MEM + N_MEM,
  localparam int O_APIC = O_REF + N_REF,
  localparam int O_USB  = O_APIC + 1,
  localparam int O_IO   = O_USB + 1,
  localparam int NPIN   = O_IO + 1
) (
  input  logic            rst_n,
  input  logic            tclk,
  input  logic [1:0]      mode,
  input  logic [NPIN-1:0] out_en,
  input  logic            cpu_clk,
  input  logic            pci_clk,
  input  logic            mem_clk,
  input  logic            ref_clk,
  input  logic            apic_clk,
  input  logic            usb_clk,
  input  logic            io_clk,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);

  localparam logic [1:0] M_TEST = 2'b01;
  localparam logic [1:0] M_HIZ  = 2'b11;

  logic tst, hiz;
  logic half, quarter;
  logic [NPIN-1:0] nsrc, tsrc;

  assign tst = (mode == M_TEST);
  assign hiz = (mode == M_HIZ);

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      half    <= 1'b0;
      quarter <= 1'b0;
    end else if (!tst) begin
      half    <= 1'b0;
      quarter <= 1'b0;
    end else begin
      half    <= ~half;
      quarter <= quarter ^ ~half;
    end
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign nsrc[O_CPU+i] = cpu_clk;
    assign tsrc[O_CPU+i] = half;
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assign nsrc[O_PCI+i] = pci_clk;
    assign tsrc[O_PCI+i] = quarter;
  end

  assign nsrc[O_PCIF] = pci_clk;
  assign tsrc[O_PCIF] = quarter;

  for (genvar i = 0; i < N_MEM; i++) begin : g_mem
    assign nsrc[O_MEM+i] = mem_clk;
    assign tsrc[O_MEM+i] = half;
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    assign nsrc[O_REF+i] = ref_clk;
    assign tsrc[O_REF+i] = tclk;
  end

  assign nsrc[O_APIC] = apic_clk;
  assign tsrc[O_APIC] = tclk;
  assign nsrc[O_USB]  = usb_clk;
  assign tsrc[O_USB]  = half;
  assign nsrc[O_IO]   = io_clk;
  assign tsrc[O_IO]   = quarter;

  assign pin_out = hiz ? '0 : (tst ? tsrc : (nsrc & out_en));
  assign pin_oe  = {NPIN{~hiz}};

endmodule

module clk_test_mux_chk #(
  parameter int N_CPU = 4,
  parameter int N_PCI = 6,
  parameter int N_MEM = 8,
  parameter int N_REF = 2,
  localparam int O_PCI = N_CPU,
  localparam int O_MEM = N_CPU + N_PCI + 1,
  localparam int NPIN  = N_CPU + N_PCI + 1 + N_MEM + N_REF + 3
) (
  input logic            rst_n,
  input logic            tclk,
  input logic [1:0]      mode,
  input logic [NPIN-1:0] out_en,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe
);

  // R3
  hiz_release_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode == 2'b11) |-> (pin_oe == '0 && pin_out == '0));

  // R1
  drive_on_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode != 2'b11) |-> (pin_oe == '1));

  // R2
  gated_low_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode[0] == 1'b0) |-> ((pin_out & ~out_en) == '0));

  // R4
  half_toggle_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01) |->
      (pin_out[0] != $past(pin_out[0]) && pin_out[O_MEM] != $past(pin_out[O_MEM])));

  // R5
  quarter_hold_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && $past(pin_out[0]) == 1'b1) |->
      $stable(pin_out[O_PCI]));

  // R7
  idle_clear_chk: assert property (@(posedge tclk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) != 2'b01) |->
      (pin_out[0] == 1'b0 && pin_out[O_PCI] == 1'b0));

endmodule

bind clk_test_mux clk_test_mux_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_MEM(N_MEM), .N_REF(N_REF)
) u_chk (
  .rst_n(rst_n), .tclk(tclk), .mode(mode), .out_en(out_en),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_clk_test_mux.sv
module sim_clk_test_mux;
  localparam int TP   = 10;
  localparam int NPIN = 24;
  localparam int NVEC = 8;

  logic rst_n = 1'b0, tclk = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [NPIN-1:0] out_en = '1;
  logic [6:0] src = '0;
  logic [NPIN-1:0] pin_out, pin_oe;
  int ntests = 0, nfail = 0;

  clk_test_mux u0 (
    .rst_n(rst_n), .tclk(tclk), .mode(mode), .out_en(out_en),
    .cpu_clk(src[6]), .pci_clk(src[5]), .mem_clk(src[4]), .ref_clk(src[3]),
    .apic_clk(src[2]), .usb_clk(src[1]), .io_clk(src[0]),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(TP/2) tclk = ~tclk;

  // {mode, enables, sources: cpu pci mem ref apic usb io}
  localparam logic [32:0] VEC [NVEC] = '{
    {2'b00, 24'hFFFFFF, 7'b1111111},
    {2'b00, 24'hFFFFFF, 7'b0000000},
    {2'b00, 24'hAAAAAA, 7'b1111111},
    {2'b00, 24'hFFFFFF, 7'b1010101},
    {2'b10, 24'h5A5A5A, 7'b0110110},
    {2'b11, 24'hFFFFFF, 7'b1111111},
    {2'b11, 24'h000000, 7'b0000000},
    {2'b00, 24'h0F0F0F, 7'b1100011}
  };

  function automatic int grp(int i);
    if (i < 4)  return 6;
    if (i < 11) return 5;
    if (i < 19) return 4;
    if (i < 21) return 3;
    if (i == 21) return 2;
    if (i == 22) return 1;
    return 0;
  endfunction

  function automatic logic [NPIN-1:0] exp_static(logic [1:0] m, logic [NPIN-1:0] en, logic [6:0] s);
    logic [NPIN-1:0] r;
    for (int i = 0; i < NPIN; i++) r[i] = (m == 2'b11) ? 1'b0 : (s[grp(i)] & en[i]);
    return r;
  endfunction

  function automatic logic [NPIN-1:0] exp_test(int k, logic thigh);
    logic [NPIN-1:0] r;
    logic h, q;
    h = (k % 2) == 1;
    q = (k % 4 == 1) || (k % 4 == 2);
    for (int i = 0; i < NPIN; i++) begin
      case (grp(i))
        6, 4, 1: r[i] = h;
        5, 0:    r[i] = q;
        default: r[i] = thigh;
      endcase
    end
    return r;
  endfunction

  task automatic chk(string req, logic [NPIN-1:0] act, logic [NPIN-1:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_test(int n, string req);
    @(negedge tclk);
    mode = 2'b01;
    for (int k = 1; k <= n; k++) begin
      @(posedge tclk); #2;
      chk(req, pin_out, exp_test(k, 1'b1));
      chk("R8", pin_oe, '1);
      #5;
      chk(req, pin_out, exp_test(k, 1'b0));
    end
  endtask

  initial begin
    #(TP * 150000);
    nfail++; ntests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    // R9: reset held in test mode, divided pins low, tclk-following pins high
    mode = 2'b01;
    @(posedge tclk); #2;
    chk("R9", pin_out, 24'h380000);
    @(posedge tclk); #2;
    chk("R9", pin_out, 24'h380000);
    @(negedge tclk);
    mode = 2'b00;
    rst_n = 1'b1;

    // R1 R2 R3: static vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge tclk);
      mode = VEC[v][32:31];
      out_en = VEC[v][30:7];
      src = VEC[v][6:0];
      #2;
      chk("R1/R2/R3 out", pin_out, exp_static(mode, out_en, src));
      chk("R1/R3 oe", pin_oe, (mode == 2'b11) ? '0 : '1);
    end

    // R4 R5 R6 R8: test mode with enables off and sources high
    @(negedge tclk);
    mode = 2'b00; out_en = '0; src = '1;
    run_test(8, "R4/R5/R6");

    // R7: leave at an odd phase, re-enter, first edge aligned
    @(negedge tclk); mode = 2'b00;
    run_test(3, "R7");
    @(negedge tclk); mode = 2'b00;
    @(posedge tclk); #2;
    chk("R7 idle", pin_out, '0);
    run_test(2, "R7");

    // R3: high impedance while the test clock runs
    @(negedge tclk); mode = 2'b11;
    #2;
    chk("R3 oe", pin_oe, '0);
    @(posedge tclk); #2;
    chk("R3 out", pin_out, '0);

    // R9: asynchronous clear during a high divider phase
    @(negedge tclk); mode = 2'b00;
    run_test(1, "R7");
    @(negedge tclk); #1;
    rst_n = 1'b0;
    #1;
    chk("R9 async", pin_out, '0);
    @(negedge tclk);
    rst_n = 1'b1;
    mode = 2'b00; out_en = 24'h000001; src = 7'b1000000;
    #2;
    chk("R2", pin_out, 24'h000001);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule